// File: doc/BRIEF.md
# ECC First-Error Capture Register

This block sits next to a memory ECC checker and keeps a record of the first error it reports. On every read the checker may pulse a correctable (single-bit) strobe or an uncorrectable (multi-bit) strobe. It also supplies the read address and the 8-bit syndrome. The block latches a flag for the kind of error and freezes the upper 19 address bits and the syndrome. It then ignores every later error until software has cleared the flag.

Software sees a single 32-bit status word. It holds the two sticky flags, the frozen address and syndrome fields, and three writable control bits. The control bits are an interrupt enable for correctable errors, a system-error enable for uncorrectable errors, and a scrub-disable bit. The block drives level outputs from the flags gated by their enables, and a scrub-enable output for the write-back logic elsewhere.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous active-low reset, `status` is all zero, `irq_ce` and `serr_ue` are 0 and `scrub_en` is 1.
- R2: With both flags clear, a correctable strobe alone sets status bit 0 (correctable flag) and leaves bit 1 at 0, visible one clock after the strobe edge.
- R3: With both flags clear, an uncorrectable strobe sets status bit 1 and leaves bit 0 at 0, also when a correctable strobe arrives in the same cycle; at most one flag is ever set.
- R4: On a capture, status bits 30:12 take address bits 31:13 and status bits 11:4 take the syndrome; the low 13 address bits are not kept.
- R5: While either flag is set, new strobes change neither flag, nor status bits 30:4.
- R6: A write with data bit 0 (or bit 1) at 1 clears the correctable (or uncorrectable) flag; a 0 in those bits has no effect; a strobe in the same cycle as the clearing write is discarded; capture resumes once both flags read 0.
- R7: A write loads status bit 31 (scrub disable), bit 3 (system-error enable) and bit 2 (interrupt enable) from the write data; written values in bits 30:4 are ignored.
- R8: `irq_ce` is high exactly when bits 0 and 2 are both 1; `serr_ue` is high exactly when bits 1 and 3 are both 1.
- R9: `scrub_en` is the inverse of status bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_err | input | 1 | Correctable-error strobe for this cycle's read |
| ue_err | input | 1 | Uncorrectable-error strobe for this cycle's read |
| err_addr | input | 32 | Address of this cycle's read |
| err_syn | input | 8 | Syndrome of this cycle's read |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status word write data |
| status | output | 32 | Status word (flags, frozen fields, control bits) |
| irq_ce | output | 1 | Correctable-error interrupt level |
| serr_ue | output | 1 | Uncorrectable-error system-error level |
| scrub_en | output | 1 | Scrub-on-corrected-read enable |

## Verification
The bench drives simultaneous strobes. A design that gives the correctable error priority would set bit 0 where bit 1 is expected, or set both flags. It sends strobes while a flag is held, including in the same cycle as the clearing write. A design that re-arms too early would overwrite the frozen address and syndrome, or set a flag right after the clear. It writes all ones into the read-only fields and writes zeros to the flag bits. A design with a wrong write mask would corrupt the capture fields or drop a flag. It also uses addresses whose low 13 bits differ from each other, to catch a slice taken one bit off.

// File: rtl/eccap_pkg.sv
// Shared layout of the status word for the ECC first-error capture block.
// Assumes the address field keeps KEEP_W upper bits and the syndrome is SYN_W wide.
package eccap_pkg;
    localparam int SYN_W  = 8;
    localparam int KEEP_W = 19;

    typedef struct packed {
        logic              scrub_off;
        logic [KEEP_W-1:0] addr_hi;
        logic [SYN_W-1:0]  syn;
        logic              serr_en;
        logic              irq_en;
        logic              ue;
        logic              ce;
    } eccap_stat_t;

    localparam int STAT_W        = $bits(eccap_stat_t);
    localparam int BIT_CE        = 0;
    localparam int BIT_UE        = 1;
    localparam int BIT_IRQ_EN    = 2;
    localparam int BIT_SERR_EN   = 3;
    localparam int BIT_SCRUB_OFF = STAT_W - 1;
endpackage

// File: rtl/eccap_flags.sv
// Sticky error flags. Capture is armed only while both flags are clear;
// an uncorrectable strobe outranks a correctable one in the same cycle.
// Assumes the clear requests are already qualified by the write strobe.
module eccap_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in,
    input  logic ue_in,
    input  logic clr_ce,
    input  logic clr_ue,
    output logic capture,
    output logic ce_q,
    output logic ue_q
);
    // Capture fires on the first strobe seen while nothing is held.
    always_comb capture = !ce_q && !ue_q && (ce_in || ue_in);

    // Flag state: set on capture, cleared by write-one requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q <= 1'b0;
            ue_q <= 1'b0;
        end else if (capture) begin
            ue_q <= ue_in;
            ce_q <= !ue_in;
        end else begin
            if (clr_ce) ce_q <= 1'b0;
            if (clr_ue) ue_q <= 1'b0;
        end
    end
endmodule

// File: rtl/eccap_record.sv
// Holds the truncated address and syndrome of the captured error.
// Assumes capture is a single-cycle pulse from the flag logic.
module eccap_record #(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 19,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SYN_W-1:0]  syn_in,
    output logic [KEEP_W-1:0] addr_hi_q,
    output logic [SYN_W-1:0]  syn_q
);
    localparam int TOP = ADDR_W - 1;

    // Freeze the upper address bits and the syndrome on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            syn_q     <= '0;
        end else if (capture) begin
            addr_hi_q <= addr_in[TOP -: KEEP_W];
            syn_q     <= syn_in;
        end
    end
endmodule

// File: rtl/eccap_ctrl.sv
// Software-writable control bits, loaded as a group on each write.
// Assumes the write data is already mapped to the control bit positions.
module eccap_ctrl #(
    parameter int N_CTL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_CTL-1:0] wr_bits,
    output logic [N_CTL-1:0] ctl_q
);
    // One register per control bit, all reset to 0.
    for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n)     ctl_q[g] <= 1'b0;
            else if (wr_en) ctl_q[g] <= wr_bits[g];
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
// ECC first-error capture register. Records the kind, upper address bits and
// syndrome of the first ECC error and holds them until software clears the flag.
// Assumes strobes are one-cycle and the address/syndrome are valid with them.
module ecc_err_capture
    import eccap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_err,
    input  logic              ue_err,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq_ce,
    output logic              serr_ue,
    output logic              scrub_en
);
    localparam int N_CTL = 3;

    logic              capture;
    logic              ce_q, ue_q;
    logic [KEEP_W-1:0] addr_hi_q;
    logic [SYN_W-1:0]  syn_q;
    logic [N_CTL-1:0]  ctl_wr, ctl_q;
    logic              clr_ce, clr_ue;
    eccap_stat_t       stat;

    // Qualify write-one-to-clear requests and pick the control bits from the data.
    always_comb begin
        clr_ce = wr_en && wr_data[BIT_CE];
        clr_ue = wr_en && wr_data[BIT_UE];
        ctl_wr = {wr_data[BIT_SCRUB_OFF], wr_data[BIT_SERR_EN], wr_data[BIT_IRQ_EN]};
    end

    eccap_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_in   (ce_err),
        .ue_in   (ue_err),
        .clr_ce  (clr_ce),
        .clr_ue  (clr_ue),
        .capture (capture),
        .ce_q    (ce_q),
        .ue_q    (ue_q)
    );

    eccap_record #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .SYN_W(SYN_W)) u_record (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .addr_in   (err_addr),
        .syn_in    (err_syn),
        .addr_hi_q (addr_hi_q),
        .syn_q     (syn_q)
    );

    eccap_ctrl #(.N_CTL(N_CTL)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (ctl_wr),
        .ctl_q   (ctl_q)
    );

    // Assemble the status word and the level outputs.
    always_comb begin
        stat.scrub_off = ctl_q[2];
        stat.addr_hi   = addr_hi_q;
        stat.syn       = syn_q;
        stat.serr_en   = ctl_q[1];
        stat.irq_en    = ctl_q[0];
        stat.ue        = ue_q;
        stat.ce        = ce_q;
        status         = stat;
        irq_ce         = ce_q && ctl_q[0];
        serr_ue        = ue_q && ctl_q[1];
        scrub_en       = !ctl_q[2];
    end
endmodule

// File: rtl/eccap_checker.sv
// Temporal checks on the ECC capture block's ports, bound to its top.
// Assumes the default status layout (flags in bits 1:0, fields in 30:4).
module eccap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_err,
    input logic        ue_err,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] status,
    input logic        irq_ce,
    input logic        serr_ue,
    input logic        scrub_en
);
    assert_ce_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00 && ce_err && !ue_err) |=> (status[0] && !status[1]));

    assert_ue_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00 && ue_err) |=> (status[1] && !status[0]));

    assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[1:0]));

    assert_fields_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != 2'b00) |=> $stable(status[30:4]));

    assert_clear_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && status[0]) |=> !status[0]);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[2] || !status[0]) |-> !irq_ce);

    assert_serr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[3] || !status[1]) |-> !serr_ue);

    assert_scrub_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[31]) |-> !scrub_en);
endmodule

bind ecc_err_capture eccap_checker i_eccap_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_err   (ce_err),
    .ue_err   (ue_err),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .status   (status),
    .irq_ce   (irq_ce),
    .serr_ue  (serr_ue),
    .scrub_en (scrub_en)
);

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_err = 1'b0, ue_err = 1'b0, wr_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  err_syn = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        irq_ce, serr_ue, scrub_en;

    int tests = 0, fails = 0;
    bit done = 0;

    // Behavioural reference state
    bit        m_ce, m_ue, m_dis, m_serr_en, m_irq_en;
    bit [18:0] m_addr;
    bit [7:0]  m_syn;

    always #4 clk = ~clk;

    ecc_err_capture i_ecc_err_capture (
        .clk(clk), .rst_n(rst_n), .ce_err(ce_err), .ue_err(ue_err),
        .err_addr(err_addr), .err_syn(err_syn), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .irq_ce(irq_ce), .serr_ue(serr_ue), .scrub_en(scrub_en)
    );

    task automatic compare(input string tag);
        logic [34:0] exp_v, act_v;
        exp_v = {m_dis, m_addr, m_syn, m_serr_en, m_irq_en, m_ue, m_ce,
                 m_ce & m_irq_en, m_ue & m_serr_en, ~m_dis};
        act_v = {status, irq_ce, serr_ue, scrub_en};
        tests++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s status/irq/serr/scrub actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    // One clock: drive at negedge, model update at the edge, compare at next negedge.
    task automatic step(input bit ce, input bit ue, input logic [31:0] a, input logic [7:0] s,
                        input bit we, input logic [31:0] wd, input string tag);
        ce_err = ce; ue_err = ue; err_addr = a; err_syn = s; wr_en = we; wr_data = wd;
        @(posedge clk);
        if (!m_ce && !m_ue) begin
            if (ue || ce) begin
                m_ue = ue; m_ce = !ue; m_addr = a[31:13]; m_syn = s;
            end
        end else if (we) begin
            if (wd[0]) m_ce = 0;
            if (wd[1]) m_ue = 0;
        end
        if (we) begin
            m_dis = wd[31]; m_serr_en = wd[3]; m_irq_en = wd[2];
        end
        @(negedge clk);
        ce_err = 0; ue_err = 0; wr_en = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        // R2 / R4: first correctable error captured
        step(1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0, "R2 R4 ce capture");
        // R5: later strobes ignored while held
        step(1, 0, 32'h1234_5678, 8'h11, 0, 0, "R5 ce ignored");
        step(0, 1, 32'h8765_4321, 8'h22, 0, 0, "R5 ue ignored");
        // R6: writing zeros does not clear
        step(0, 0, 0, 0, 1, 32'h0, "R6 zero write no effect");
        // R7 / R8: enable interrupt, read-only fields untouched by all-ones data
        step(0, 0, 0, 0, 1, 32'h7FFF_FFF4, "R7 R8 irq enable");
        // R6: clear with coincident strobe, strobe discarded
        step(0, 1, 32'hAAAA_0000, 8'h33, 1, 32'h0000_0005, "R6 clear discards strobe");
        // R3: both strobes, uncorrectable wins
        step(1, 1, 32'hFFFF_E000, 8'hC3, 0, 0, "R3 R4 ue wins");
        step(0, 0, 0, 0, 1, 32'h0000_000C, "R8 serr enable");
        // R9: scrub disable
        step(0, 0, 0, 0, 1, 32'h8000_000C, "R9 scrub off");
        // R6: clearing the wrong flag has no effect
        step(1, 0, 32'h0, 8'h1, 1, 32'h8000_0001, "R6 wrong flag clear");
        step(0, 0, 0, 0, 1, 32'h8000_0002, "R6 ue cleared");
        // R4: low 13 address bits dropped
        step(1, 0, 32'h0000_3FFF, 8'hFF, 0, 0, "R4 truncation");
        step(0, 0, 0, 0, 1, 32'h0000_0001, "R9 R6 scrub on, clear");
        step(1, 0, 32'h0000_2000, 8'h01, 0, 0, "R4 lsb kept bit");
        // Mixed traffic
        r = 32'h1ACE_B00C;
        for (int i = 0; i < 300; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            step(r[1:0] == 2'b00, r[4:2] == 3'b000, r, r[15:8], r[7:6] == 2'b00,
                 {r[31], r[30:4] ^ r[26:0], r[3:2], r[20:19]}, "R5 R6 R7 mixed");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule